// File: doc/BRIEF.md
# LIN Receive Error Flag Unit

This block sits behind a LIN protocol engine and turns the engine's per-event strobes into sticky status flags that software can read and clear. It judges the events itself where the judgement is simple: it compares the received checksum byte against the engine's computed one, compares a measured break-delimiter length against the current bit time, and checks the two parity bits of the protected identifier. Synch-field inconsistency, stop-bit validity and noise arrive as ready-made indications from the engine.

The block also holds a one-byte receive buffer for response bytes. A small state machine with the states `BUF_EMPTY` and `BUF_FULL` tracks whether the buffer holds a byte that software has not yet acknowledged. The transitions are `LOAD` (`BUF_EMPTY` to `BUF_FULL` on a response byte), `OVERRUN` (`BUF_FULL` to `BUF_FULL` on a response byte) and `RELEASE` (`BUF_FULL` to `BUF_EMPTY` on a software clear of the full flag with no byte arriving). When an overrun happens, a lock control decides whether the stored byte is kept or replaced.

A level-sensitive header interrupt combines the three header-related errors under one enable. Flags update on the clock edge after their event. Software clears flags by writing a mask, and a hardware set in the same cycle as a clear takes priority.

Top module: `lin_rx_err_unit`

## Requirements
- R1: After reset, `flags_o`, `rx_data_o` and `hdr_irq_o` are all zero.
- R2: A `cksum_done_i` strobe with `cksum_rx_i` different from `cksum_calc_i` sets flag bit 7 at the next edge. Equal values do not set it. The bit never sets while `cksum_calc_dis_i` or `cksum_field_dis_i` is high.
- R3: A `synch_err_i` strobe sets flag bit 6.
- R4: A `delim_done_i` strobe with `delim_len_i` strictly less than `bit_time_i` sets flag bit 5. A length equal to or greater than the bit time does not set it.
- R5: A `pid_valid_i` strobe sets flag bit 4 when `pid_i[6]` differs from id0^id1^id2^id4 or `pid_i[7]` differs from the inverse of id1^id3^id4^id5, where id means `pid_i[5:0]`.
- R6: A `byte_valid_i` with `stop_ok_i` low sets flag bit 3 when `byte_kind_i` is 0 (response). For kinds 1 (synch) and 2 (identifier) it sets the bit only when `slave_mode_i` is high. Kind 3 never sets it.
- R7: A `byte_valid_i` with `noise_i` high sets flag bit 1, whatever the kind.
- R8: A response byte (kind 0) arriving while flag bit 0 is clear is stored in `rx_data_o` and sets flag bit 0. Bytes of other kinds never touch the buffer.
- R9: A response byte arriving while flag bit 0 is set (as registered before that edge) sets flag bit 2. With `buf_lock_i` high the stored byte is kept. With it low the new byte replaces it.
- R10: A one in `clr_i[k]` clears flag k at the next edge, and a zero leaves it unchanged. A set event for the same flag in the same cycle wins. All flags stay set until cleared.
- R11: `hdr_irq_o` is high exactly while `hdr_irq_en_i` is high and any of flag bits 4, 5 or 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cksum_done_i | input | 1 | Checksum byte received strobe |
| cksum_rx_i | input | 8 | Received checksum byte |
| cksum_calc_i | input | 8 | Locally computed checksum |
| cksum_calc_dis_i | input | 1 | Checksum calculation disabled |
| cksum_field_dis_i | input | 1 | Checksum field disabled |
| synch_err_i | input | 1 | Synch field inconsistency strobe |
| delim_done_i | input | 1 | Break delimiter measured strobe |
| delim_len_i | input | CNT_W | Measured delimiter length |
| bit_time_i | input | CNT_W | One bit time in the same units |
| pid_valid_i | input | 1 | Protected identifier received strobe |
| pid_i | input | 8 | Protected identifier byte |
| byte_valid_i | input | 1 | Received character strobe |
| byte_i | input | 8 | Received character |
| byte_kind_i | input | 2 | 0 response, 1 synch, 2 identifier, 3 other |
| stop_ok_i | input | 1 | Stop bit was valid |
| noise_i | input | 1 | Noise seen on the character |
| slave_mode_i | input | 1 | Node operates as slave |
| buf_lock_i | input | 1 | Keep old byte on overrun |
| hdr_irq_en_i | input | 1 | Header error interrupt enable |
| clr_i | input | 8 | Write-one-to-clear mask for the flags |
| flags_o | output | 8 | Flags: 7 checksum, 6 synch, 5 delimiter, 4 parity, 3 framing, 2 overrun, 1 noise, 0 full |
| rx_data_o | output | 8 | Buffered response byte |
| hdr_irq_o | output | 1 | Header error interrupt level |

## Verification
The hardest situations to reach are the ones where one edge carries a clear of a flag together with an event that sets the same flag. The most delicate of these is a response byte arriving in the same cycle that software clears the full flag. Whether that byte counts as an overrun, and whether the lock keeps it out, depends on the registered state and not on the clear. The stimulus places the clear mask and the strobe on the same cycle on purpose, once with the lock set and once with it clear. A behavioural reference model, compared on every clock, then confirms that the flags, the buffered byte and the interrupt all follow the set-wins rule.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;

    localparam int NFLAG = 8;
    localparam int DW    = 8;

    typedef enum logic [2:0] {
        F_FULL  = 3'd0,
        F_NOISE = 3'd1,
        F_OVR   = 3'd2,
        F_FRM   = 3'd3,
        F_PAR   = 3'd4,
        F_DELIM = 3'd5,
        F_SYNCH = 3'd6,
        F_CKS   = 3'd7
    } flag_idx_e;

    localparam logic [1:0] K_RESP  = 2'd0;
    localparam logic [1:0] K_SYNCH = 2'd1;
    localparam logic [1:0] K_PID   = 2'd2;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

endpackage

// File: rtl/pid_parity_chk.sv
module pid_parity_chk (
    input  logic [7:0] pid_i,
    output logic       bad_o
);
    logic p0_exp;
    logic p1_exp;

    always_comb begin
        p0_exp = pid_i[0] ^ pid_i[1] ^ pid_i[2] ^ pid_i[4];
        p1_exp = ~(pid_i[1] ^ pid_i[3] ^ pid_i[4] ^ pid_i[5]);
        bad_o  = (pid_i[6] != p0_exp) || (pid_i[7] != p1_exp);
    end
endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_o[k] <= 1'b0;
            end else if (set_i[k]) begin
                flags_o[k] <= 1'b1;
            end else if (clr_i[k]) begin
                flags_o[k] <= 1'b0;
            end
        end

        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[k] && !clr_i[k]) |=> flags_o[k])
            else $error("flag %0d dropped without clear", k);

        p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k])
            else $error("flag %0d survived clear", k);

        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k])
            else $error("flag %0d set lost", k);
    end
endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
    import lin_err_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         lock_i,
    input  logic         clr_full_i,
    output logic         full_o,
    output logic         ovr_o,
    output logic [W-1:0] data_o
);
    buf_state_e state_q;
    buf_state_e state_d;
    logic       load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: LOAD, OVERRUN, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (wr_i) state_d = BUF_FULL;
            BUF_FULL: begin
                if (wr_i)            state_d = BUF_FULL;
                else if (clr_full_i) state_d = BUF_EMPTY;
            end
        endcase
    end

    // outputs
    always_comb begin
        full_o = (state_q == BUF_FULL);
        ovr_o  = wr_i && (state_q == BUF_FULL);
        load   = wr_i && ((state_q == BUF_EMPTY) || !lock_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_o <= '0;
        else if (load) data_o <= data_i;
    end

    p_lock_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && lock_i) |=> $stable(data_o))
        else $error("locked buffer overwritten");

    p_load_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !full_o) |=> (full_o && data_o == $past(data_i)))
        else $error("empty buffer did not load");

    p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !lock_i) |=> (data_o == $past(data_i)))
        else $error("unlocked overrun did not overwrite");
endmodule

// File: rtl/lin_rx_err_unit.sv
module lin_rx_err_unit
    import lin_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cksum_done_i,
    input  logic [7:0]       cksum_rx_i,
    input  logic [7:0]       cksum_calc_i,
    input  logic             cksum_calc_dis_i,
    input  logic             cksum_field_dis_i,
    input  logic             synch_err_i,
    input  logic             delim_done_i,
    input  logic [CNT_W-1:0] delim_len_i,
    input  logic [CNT_W-1:0] bit_time_i,
    input  logic             pid_valid_i,
    input  logic [7:0]       pid_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    input  logic [1:0]       byte_kind_i,
    input  logic             stop_ok_i,
    input  logic             noise_i,
    input  logic             slave_mode_i,
    input  logic             buf_lock_i,
    input  logic             hdr_irq_en_i,
    input  logic [7:0]       clr_i,
    output logic [7:0]       flags_o,
    output logic [7:0]       rx_data_o,
    output logic             hdr_irq_o
);
    localparam int NB = NFLAG - 1;

    logic          pid_bad;
    logic          full;
    logic          ovr_evt;
    logic          resp_wr;
    logic          frm_evt;
    logic [NFLAG-1:0] set_vec;
    logic [NB-1:0] bank_q;

    pid_parity_chk u_par (
        .pid_i (pid_i),
        .bad_o (pid_bad)
    );

    always_comb begin
        resp_wr = byte_valid_i && (byte_kind_i == K_RESP);
        frm_evt = byte_valid_i && !stop_ok_i &&
                  ((byte_kind_i == K_RESP) ||
                   (slave_mode_i && ((byte_kind_i == K_SYNCH) || (byte_kind_i == K_PID))));
        set_vec          = '0;
        set_vec[F_CKS]   = cksum_done_i && (cksum_rx_i != cksum_calc_i) &&
                           !cksum_calc_dis_i && !cksum_field_dis_i;
        set_vec[F_SYNCH] = synch_err_i;
        set_vec[F_DELIM] = delim_done_i && (delim_len_i < bit_time_i);
        set_vec[F_PAR]   = pid_valid_i && pid_bad;
        set_vec[F_FRM]   = frm_evt;
        set_vec[F_OVR]   = ovr_evt;
        set_vec[F_NOISE] = byte_valid_i && noise_i;
    end

    rx_byte_buffer #(.W(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (resp_wr),
        .data_i     (byte_i),
        .lock_i     (buf_lock_i),
        .clr_full_i (clr_i[F_FULL]),
        .full_o     (full),
        .ovr_o      (ovr_evt),
        .data_o     (rx_data_o)
    );

    sticky_flag_bank #(.N(NB)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec[NFLAG-1:1]),
        .clr_i   (clr_i[NFLAG-1:1]),
        .flags_o (bank_q)
    );

    always_comb begin
        flags_o   = {bank_q, full};
        hdr_irq_o = hdr_irq_en_i &&
                    (flags_o[F_SYNCH] || flags_o[F_DELIM] || flags_o[F_PAR]);
    end

    p_cks_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cksum_calc_dis_i || cksum_field_dis_i) && !flags_o[F_CKS]) |=> !flags_o[F_CKS])
        else $error("checksum flag set while disabled");

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_irq_o && clr_i[6:4] == 3'b000) |=> (hdr_irq_o || !hdr_irq_en_i))
        else $error("header irq dropped while flags held");

    p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[F_OVR]) |-> $past(full))
        else $error("overrun without full buffer");
endmodule

// File: tb/tb_lin_rx_err_unit.sv
module tb_lin_rx_err_unit;
    localparam int CLK_PER = 10;
    localparam int CW = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic cksum_done = 0, cdis = 0, fdis = 0, synch = 0, ddone = 0, pvalid = 0;
    logic bvalid = 0, stop_ok = 1, noise = 0, slave = 0, lock = 0, irq_en = 0;
    logic [7:0] crx = 0, ccalc = 0, pid = 0, bdata = 0, clr = 0;
    logic [CW-1:0] dlen = 0, btime = 0;
    logic [1:0] kind = 0;
    logic [7:0] flags, rdata;
    logic irq;

    int checks = 0, errors = 0;
    int m_flags = 0, m_data = 0;

    always #(CLK_PER/2) clk = ~clk;

    lin_rx_err_unit #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cksum_done_i(cksum_done), .cksum_rx_i(crx), .cksum_calc_i(ccalc),
        .cksum_calc_dis_i(cdis), .cksum_field_dis_i(fdis),
        .synch_err_i(synch), .delim_done_i(ddone), .delim_len_i(dlen),
        .bit_time_i(btime), .pid_valid_i(pvalid), .pid_i(pid),
        .byte_valid_i(bvalid), .byte_i(bdata), .byte_kind_i(kind),
        .stop_ok_i(stop_ok), .noise_i(noise), .slave_mode_i(slave),
        .buf_lock_i(lock), .hdr_irq_en_i(irq_en), .clr_i(clr),
        .flags_o(flags), .rx_data_o(rdata), .hdr_irq_o(irq)
    );

    function automatic bit pid_ok(input logic [7:0] p);
        logic e0, e1;
        e0 = ^(p[5:0] & 6'b010111);
        e1 = ~(^(p[5:0] & 6'b111010));
        return (p[6] == e0) && (p[7] == e1);
    endfunction

    function automatic string tag(input int b);
        case (b)
            0: return "R8";
            1: return "R7";
            2: return "R9";
            3: return "R6";
            4: return "R5";
            5: return "R4";
            6: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = 0;
            m_data = 0;
        end else begin
            int s;
            bit was_full;
            s = 0;
            was_full = m_flags[0];
            if (cksum_done && crx != ccalc && !cdis && !fdis) s |= 128;
            if (synch) s |= 64;
            if (ddone && int'(dlen) < int'(btime)) s |= 32;
            if (pvalid && !pid_ok(pid)) s |= 16;
            if (bvalid && !stop_ok &&
                (kind == 0 || (slave && (kind == 1 || kind == 2)))) s |= 8;
            if (bvalid && noise) s |= 2;
            if (bvalid && kind == 0) begin
                s |= 1;
                if (was_full) s |= 4;
                if (!was_full || !lock) m_data = int'(bdata);
            end
            m_flags = (m_flags & ~int'(clr)) | s;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_irq;
            for (int b = 0; b < 8; b++) chk(tag(b), int'(flags[b]), (m_flags >> b) & 1);
            chk("R8", int'(rdata), m_data);
            exp_irq = (irq_en && (m_flags & 112) != 0) ? 1 : 0;
            chk("R11", int'(irq), exp_irq);
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic quiet();
        cksum_done = 0; synch = 0; ddone = 0; pvalid = 0; bvalid = 0;
        noise = 0; stop_ok = 1; clr = 0;
    endtask

    task automatic step();
        cyc();
        quiet();
    endtask

    task automatic clear_all();
        clr = 8'hFF;
        step();
    endtask

    task automatic send_byte(input logic [7:0] d, input logic [1:0] k);
        bvalid = 1; bdata = d; kind = k;
        step();
    endtask

    initial begin
        #(CLK_PER * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(); cyc();
        // R1: reset state
        chk("R1", int'(flags), 0);
        chk("R1", int'(rdata), 0);
        chk("R1", int'(irq), 0);
        rst_n = 1;
        cyc();

        // R2: checksum
        cksum_done = 1; crx = 8'h5A; ccalc = 8'h5A; step(); cyc();
        chk("R2", int'(flags[7]), 0);
        cdis = 1; cksum_done = 1; ccalc = 8'h11; step(); cyc();
        chk("R2", int'(flags[7]), 0);
        cdis = 0; fdis = 1; cksum_done = 1; step(); cyc();
        chk("R2", int'(flags[7]), 0);
        fdis = 0; cksum_done = 1; step(); cyc();
        chk("R2", int'(flags[7]), 1);

        // R3: synch error
        synch = 1; step(); cyc();
        chk("R3", int'(flags[6]), 1);

        // R4: delimiter
        clear_all();
        ddone = 1; dlen = 16'd40; btime = 16'd40; step(); cyc();
        chk("R4", int'(flags[5]), 0);
        ddone = 1; dlen = 16'd39; step(); cyc();
        chk("R4", int'(flags[5]), 1);

        // R11: interrupt follows enable and header flags
        irq_en = 1; cyc();
        chk("R11", int'(irq), 1);
        clear_all(); cyc();
        chk("R11", int'(irq), 0);

        // R5: identifier parity, all ids with correct and corrupted parity
        for (int id = 0; id < 64; id++) begin
            logic [7:0] p;
            p[5:0] = 6'(id);
            p[6] = ^(p[5:0] & 6'b010111);
            p[7] = ~(^(p[5:0] & 6'b111010));
            pvalid = 1; pid = p; step();
            if (flags[4]) begin clr = 8'h10; step(); end
            pvalid = 1; pid = p ^ 8'h80; step(); cyc();
            chk("R5", int'(flags[4]), 1);
            chk("R11", int'(irq), 1);
            clr = 8'h10; step();
        end

        // R6: framing by kind and role
        clear_all();
        slave = 0; stop_ok = 0; bvalid = 1; bdata = 8'h01; kind = 1; step(); cyc();
        chk("R6", int'(flags[3]), 0);
        stop_ok = 0; bvalid = 1; kind = 2; step(); cyc();
        chk("R6", int'(flags[3]), 0);
        slave = 1; stop_ok = 0; bvalid = 1; kind = 1; step(); cyc();
        chk("R6", int'(flags[3]), 1);
        clr = 8'h08; step();
        stop_ok = 0; bvalid = 1; kind = 3; step(); cyc();
        chk("R6", int'(flags[3]), 0);
        slave = 0; stop_ok = 0; bvalid = 1; kind = 0; bdata = 8'h33; step(); cyc();
        chk("R6", int'(flags[3]), 1);
        chk("R8", int'(rdata), 8'h33);

        // R7: noise on a header byte, buffer untouched
        clear_all();
        noise = 1; bvalid = 1; kind = 1; bdata = 8'hEE; step(); cyc();
        chk("R7", int'(flags[1]), 1);
        chk("R8", int'(flags[0]), 0);
        chk("R8", int'(rdata), 8'h33);

        // R8, R9: buffer and overrun with lock
        clear_all();
        lock = 1;
        send_byte(8'hA1, 0); cyc();
        chk("R8", int'(rdata), 8'hA1);
        chk("R8", int'(flags[0]), 1);
        send_byte(8'hB2, 0); cyc();
        chk("R9", int'(flags[2]), 1);
        chk("R9", int'(rdata), 8'hA1);
        lock = 0;
        send_byte(8'hC3, 0); cyc();
        chk("R9", int'(rdata), 8'hC3);

        // R10: zero mask has no effect, set wins over clear
        clr = 8'h00; step(); cyc();
        chk("R10", int'(flags[2:0]), 3'b101);
        clr = 8'h04; bvalid = 1; kind = 0; bdata = 8'hD4; step(); cyc();
        chk("R10", int'(flags[2]), 1);
        // clear full and byte in the same cycle under lock: still an overrun, byte dropped
        lock = 1; clr = 8'h05; bvalid = 1; kind = 0; bdata = 8'hE5; step(); cyc();
        chk("R10", int'(flags[0]), 1);
        chk("R9", int'(flags[2]), 1);
        chk("R9", int'(rdata), 8'hD4);
        clr = 8'h01; step(); cyc();
        chk("R10", int'(flags[0]), 0);
        chk("R10", int'(flags[2]), 1);
        lock = 0;
        send_byte(8'h77, 0); cyc();
        chk("R8", int'(rdata), 8'h77);
        clear_all(); cyc();
        chk("R10", int'(flags), 0);

        repeat (3) cyc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule